// File: doc/BRIEF.md
# Converter Power-State and Conversion-Clock Manager

This block tracks the operating state of a serial successive-approximation converter. It decides whether the converter is powered or asleep, and whether a conversion runs on its own internal clock or on the host's serial clock. When the internal clock is used, it also sets the rate of that clock. It consumes one event per accepted control byte, together with that byte's two-bit power/clock field. It also consumes a start-bit event, a conversion-done event that the serial engine raises in external-clock mode, and a three-level shutdown pin. The pin arrives already encoded into two bits.

The internal conversion clock is modelled as a tick enable, divided from a free-running reference clock. A fast divider applies while the shutdown pin floats, and a slow divider applies while it is driven high. An internal-mode conversion lasts a fixed number of these ticks. For that whole time the active-low conversion strobe is held low. A software power-down request is deferred until the conversion it arrives with has finished. Driving the shutdown pin low overrides the software bits and stops work at once. After reset, a power-on timer must expire before any control event is honoured.

Top module: `adc_pwr_mode_mgr`

## Requirements
- R1: While reset is held, the outputs read: strobe = 1, ext_mode = 0 (internal clock), result_ready = 0, por_done = 0, pwr_up = 1 (with the shutdown pin not low).
- R2: por_done rises exactly POR_CYCLES reference cycles after reset release, provided shdn_lvl is not low. Before that, ctrl_valid and start_bit have no effect: strobe stays 1 and result_ready stays 0.
- R3: ctrl_pd encodes the power/clock field of each accepted byte as follows. 2'b11 selects external clock (ext_mode = 1). 2'b10 selects internal clock (ext_mode = 0). 2'b01 is unassigned: it keeps the previous ext_mode and does not request power-down. 2'b00 requests power-down and keeps the previous ext_mode.
- R4: With shdn_lvl = 2'b01 (open), an internal-mode byte holds strobe low for exactly CONV_STEPS*FAST_DIV cycles, beginning in the cycle after ctrl_valid is sampled. slow_sel reads 0.
- R5: With shdn_lvl = 2'b10 (high), slow_sel reads 1 and an internal-mode conversion holds strobe low for exactly CONV_STEPS*SLOW_DIV cycles.
- R6: A byte with ctrl_pd = 2'b00 keeps pwr_up = 1 until its conversion ends. In internal mode the end is the rise of strobe. In external mode it is the cycle after conv_done. From that point pwr_up = 0.
- R7: In external-clock mode strobe stays 1, and the conversion ends on the cycle after a conv_done pulse.
- R8: A start_bit pulse returns pwr_up to 1 in the following cycle after a software power-down.
- R9: shdn_lvl = 2'b00 (low) forces pwr_up to 0 at once. It abandons a running conversion (strobe returns to 1 on the next cycle) and clears result_ready. ctrl_valid is ignored while the pin stays low. Encoding 2'b11 is treated as open.
- R10: result_ready sets when a conversion completes. It is held through a software power-down and through a wake-up, and is cleared by the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| shdn_lvl | input | 2 | Encoded shutdown pin: 00 low, 01 open, 10 high, 11 as open |
| start_bit | input | 1 | One-cycle pulse: a start bit was seen on the serial input |
| ctrl_valid | input | 1 | One-cycle pulse: a full control byte was accepted |
| ctrl_pd | input | 2 | Power/clock field of that byte |
| conv_done | input | 1 | One-cycle pulse: external-clock conversion finished |
| pwr_up | output | 1 | 1 while the converter is powered |
| ext_mode | output | 1 | 1 = conversion on serial clock, 0 = internal clock |
| slow_sel | output | 1 | Internal clock divider select, 1 = slow rate |
| conv_tick | output | 1 | Internal conversion clock enable |
| strobe | output | 1 | Active-low internal-mode busy strobe |
| result_ready | output | 1 | A completed result is available to read |
| por_done | output | 1 | Power-on interval has elapsed |

## Verification
Several rules are checked by assertions on every cycle. External mode never pulls the strobe low, and an unassigned code never changes the clock mode. Software power-down only ever lands on the cycle a conversion ends. A low pin always leaves the strobe high and no result ready one cycle later. Once the power-on timer has fired it stays fired. Other behaviours can only be shown by the bench scenarios. These are the exact strobe lengths at both divider rates, the deferral of power-down across a whole conversion, a start bit waking the block, and a result surviving a power-down. The bench also confirms that a conversion abandoned by the pin is cut short at the expected cycle.

// File: rtl/adc_pm_pkg.sv
// Package: shared encodings for the power and clock-mode manager.
// Assumes the shutdown pin has been resolved into a 2-bit level code upstream.
package adc_pm_pkg;
    // encoded three-level shutdown pin
    localparam logic [1:0] SHDN_LOW  = 2'b00;
    localparam logic [1:0] SHDN_OPEN = 2'b01;
    localparam logic [1:0] SHDN_HIGH = 2'b10;

    // power/clock field of a control byte
    localparam logic [1:0] PD_SLEEP = 2'b00;
    localparam logic [1:0] PD_NONE  = 2'b01;
    localparam logic [1:0] PD_INT   = 2'b10;
    localparam logic [1:0] PD_EXT   = 2'b11;

    // Next clock-mode flag for a field; codes that name no mode keep the old one.
    function automatic logic pick_ext(input logic [1:0] pd, input logic cur);
        case (pd)
            PD_EXT:  return 1'b1;
            PD_INT:  return 1'b0;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/adc_pm_por_timer.sv
// Power-on timer: counts reference cycles after reset release and raises
// done after POR_CYCLES of them. Assumes the count pauses while the
// shutdown pin holds the part off.
module adc_pm_por_timer #(
    parameter int POR_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_off,
    output logic done
);
    localparam int CNT_W = $clog2(POR_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count up to the power-on interval, then latch done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done && !hw_off) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(POR_CYCLES - 1)) done <= 1'b1;
        end
    end

    // R2
    por_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/adc_pm_conv_clock.sv
// Internal conversion clock: divides the reference clock by a fast or slow
// ratio and runs a conversion for CONV_STEPS divided ticks. Assumes start
// and clear are never both asserted; clear wins if they are.
module adc_pm_conv_clock #(
    parameter int FAST_DIV   = 3,
    parameter int SLOW_DIV   = 20,
    parameter int CONV_STEPS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic slow_sel,
    output logic active,
    output logic tick,
    output logic last
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);
    localparam int STEP_W  = $clog2(CONV_STEPS + 1);

    logic [DIV_W-1:0]  div_cnt;
    logic [STEP_W-1:0] step;
    logic [DIV_W-1:0]  div_lim;

    // Terminal divider count for the selected rate.
    always_comb begin
        div_lim = slow_sel ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
        tick    = active && (div_cnt == div_lim);
        last    = tick && (step == STEP_W'(CONV_STEPS - 1));
    end

    // Run the divider and step counter while a conversion is active.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            active  <= 1'b0;
            div_cnt <= '0;
            step    <= '0;
        end else if (start) begin
            active  <= 1'b1;
            div_cnt <= '0;
            step    <= '0;
        end else if (active) begin
            if (tick) begin
                div_cnt <= '0;
                if (last) active <= 1'b0;
                else      step   <= step + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R4
    conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));
endmodule

// File: rtl/adc_pm_mode_ctl.sv
// Mode controller: holds the clock-mode flag, the software sleep state, a
// deferred sleep request and the result-ready flag. Assumes start_bit and
// ctrl_valid come from the serial front end as single-cycle pulses.
module adc_pm_mode_ctl
    import adc_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_off,
    input  logic       por_done,
    input  logic       start_bit,
    input  logic       ctrl_valid,
    input  logic [1:0] ctrl_pd,
    input  logic       conv_done,
    input  logic       int_last,
    output logic       ext_mode,
    output logic       soft_down,
    output logic       int_start,
    output logic       int_clear,
    output logic       result_ready
);
    logic accept, wake, new_ext, ext_busy, pend_down, finish;

    // Qualify events and derive the conversion start/clear controls.
    always_comb begin
        accept    = ctrl_valid && por_done && !hw_off;
        wake      = start_bit && por_done && !hw_off;
        new_ext   = pick_ext(ctrl_pd, ext_mode);
        int_start = accept && !new_ext;
        int_clear = hw_off || (accept && new_ext);
        finish    = !accept && !hw_off && (int_last || (ext_busy && conv_done));
    end

    // Update mode, sleep state, deferred request and result flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_mode     <= 1'b0;
            soft_down    <= 1'b0;
            pend_down    <= 1'b0;
            ext_busy     <= 1'b0;
            result_ready <= 1'b0;
        end else if (hw_off) begin
            ext_busy     <= 1'b0;
            pend_down    <= 1'b0;
            result_ready <= 1'b0;
        end else if (accept) begin
            ext_mode     <= new_ext;
            ext_busy     <= new_ext;
            pend_down    <= (ctrl_pd == PD_SLEEP);
            soft_down    <= 1'b0;
            result_ready <= 1'b0;
        end else begin
            if (wake) soft_down <= 1'b0;
            if (finish) begin
                ext_busy     <= 1'b0;
                result_ready <= 1'b1;
                if (pend_down) begin
                    soft_down <= 1'b1;
                    pend_down <= 1'b0;
                end
            end
        end
    end

    // R3
    unassigned_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ctrl_pd == PD_NONE) |=> $stable(ext_mode));

    // R6
    sleep_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_down) |-> $past(int_last || (ext_busy && conv_done)));
endmodule

// File: rtl/adc_pwr_mode_mgr.sv
// Top: power-state and conversion-clock manager for a serial SAR converter.
// Decodes the shutdown pin, then wires the power-on timer, mode controller
// and internal conversion clock together. Assumes shdn_lvl is synchronous.
module adc_pwr_mode_mgr
    import adc_pm_pkg::*;
#(
    parameter int FAST_DIV   = 3,
    parameter int SLOW_DIV   = 20,
    parameter int CONV_STEPS = 12,
    parameter int POR_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] shdn_lvl,
    input  logic       start_bit,
    input  logic       ctrl_valid,
    input  logic [1:0] ctrl_pd,
    input  logic       conv_done,
    output logic       pwr_up,
    output logic       ext_mode,
    output logic       slow_sel,
    output logic       conv_tick,
    output logic       strobe,
    output logic       result_ready,
    output logic       por_done
);
    logic hw_off, soft_down, int_start, int_clear, int_active, int_last;

    // Pin decode and the combined power and strobe outputs.
    always_comb begin
        hw_off   = (shdn_lvl == SHDN_LOW);
        slow_sel = (shdn_lvl == SHDN_HIGH);
        pwr_up   = !hw_off && !soft_down;
        strobe   = !int_active;
    end

    adc_pm_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_off (hw_off),
        .done   (por_done)
    );

    adc_pm_mode_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_off       (hw_off),
        .por_done     (por_done),
        .start_bit    (start_bit),
        .ctrl_valid   (ctrl_valid),
        .ctrl_pd      (ctrl_pd),
        .conv_done    (conv_done),
        .int_last     (int_last),
        .ext_mode     (ext_mode),
        .soft_down    (soft_down),
        .int_start    (int_start),
        .int_clear    (int_clear),
        .result_ready (result_ready)
    );

    adc_pm_conv_clock #(
        .FAST_DIV   (FAST_DIV),
        .SLOW_DIV   (SLOW_DIV),
        .CONV_STEPS (CONV_STEPS)
    ) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (int_start),
        .clear    (int_clear),
        .slow_sel (slow_sel),
        .active   (int_active),
        .tick     (conv_tick),
        .last     (int_last)
    );

    // R9
    pin_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_lvl == SHDN_LOW) |=> (strobe && !result_ready));

    // R7
    ext_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> strobe);

    // R2
    no_conv_before_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |-> strobe);
endmodule

// File: tb/adc_pwr_mode_mgr_tb.sv
// Scoreboard bench: driver pushes expected strobe-low lengths, monitor
// measures each low pulse and compares; direct checks cover the rest.
module adc_pwr_mode_mgr_tb;
    localparam int FAST_DIV   = 3;
    localparam int SLOW_DIV   = 20;
    localparam int CONV_STEPS = 12;
    localparam int POR_CYCLES = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] shdn_lvl = 2'b01;
    logic       start_bit = 1'b0, ctrl_valid = 1'b0, conv_done = 1'b0;
    logic [1:0] ctrl_pd = 2'b00;
    logic pwr_up, ext_mode, slow_sel, conv_tick, strobe, result_ready, por_done;

    adc_pwr_mode_mgr #(
        .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV),
        .CONV_STEPS(CONV_STEPS), .POR_CYCLES(POR_CYCLES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .shdn_lvl(shdn_lvl), .start_bit(start_bit),
        .ctrl_valid(ctrl_valid), .ctrl_pd(ctrl_pd), .conv_done(conv_done),
        .pwr_up(pwr_up), .ext_mode(ext_mode), .slow_sel(slow_sel),
        .conv_tick(conv_tick), .strobe(strobe), .result_ready(result_ready),
        .por_done(por_done)
    );

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    bit finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measure each strobe-low pulse and compare with the queue.
    int low_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) low_cnt = 0;
        else if (strobe === 1'b0) low_cnt++;
        else if (low_cnt > 0) begin
            if (exp_q.size() == 0) check("R4 unexpected strobe pulse", low_cnt, 0);
            else check("R4/R5/R9 strobe low length", low_cnt, exp_q.pop_front());
            low_cnt = 0;
        end
    end

    task automatic send_ctrl(input logic [1:0] pd);
        @(negedge clk); ctrl_valid = 1'b1; ctrl_pd = pd;
        @(negedge clk); ctrl_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_bit = 1'b1;
        @(negedge clk); start_bit = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 strobe", strobe, 1);
        check("R1 ext_mode", ext_mode, 0);
        check("R1 result_ready", result_ready, 0);
        check("R1 por_done", por_done, 0);
        check("R1 pwr_up", pwr_up, 1);
        rst_n = 1'b1;
        // R2: control byte during power-on interval is ignored
        @(negedge clk); ctrl_valid = 1'b1; ctrl_pd = 2'b10;
        @(negedge clk); ctrl_valid = 1'b0;
        check("R2 strobe during por", strobe, 1);
        check("R2 result_ready during por", result_ready, 0);
        repeat (POR_CYCLES - 3) @(negedge clk);
        check("R2 por_done early", por_done, 0);
        @(negedge clk);
        check("R2 por_done on time", por_done, 1);

        // R4 fast internal conversion
        check("R4 slow_sel open", slow_sel, 0);
        exp_q.push_back(CONV_STEPS * FAST_DIV);
        send_ctrl(2'b10);
        wait_drain();
        check("R10 ready after internal conv", result_ready, 1);
        check("R3 code 10 internal", ext_mode, 0);

        // R5 slow internal conversion
        @(negedge clk); shdn_lvl = 2'b10;
        @(negedge clk);
        check("R5 slow_sel high", slow_sel, 1);
        exp_q.push_back(CONV_STEPS * SLOW_DIV);
        send_ctrl(2'b10);
        wait_drain();
        shdn_lvl = 2'b01;
        @(negedge clk);
        check("R5 slow_sel back", slow_sel, 0);

        // R7 external conversion
        send_ctrl(2'b11);
        check("R3 code 11 external", ext_mode, 1);
        check("R10 ready cleared by byte", result_ready, 0);
        repeat (5) @(negedge clk);
        check("R7 strobe high in external", strobe, 1);
        check("R7 still converting", result_ready, 0);
        pulse_done();
        check("R7 done ends conversion", result_ready, 1);

        // R3 unassigned code keeps mode, no sleep
        send_ctrl(2'b01);
        check("R3 code 01 keeps mode", ext_mode, 1);
        pulse_done();
        check("R3 code 01 stays powered", pwr_up, 1);

        // R6 deferred sleep in external mode, R8 wake
        send_ctrl(2'b00);
        repeat (5) @(negedge clk);
        check("R6 powered during ext conv", pwr_up, 1);
        pulse_done();
        check("R6 asleep after ext conv", pwr_up, 0);
        check("R10 ready held in sleep", result_ready, 1);
        pulse_start();
        check("R8 start bit wakes", pwr_up, 1);
        check("R10 ready held after wake", result_ready, 1);

        // R6 deferred sleep in internal mode
        exp_q.push_back(CONV_STEPS * FAST_DIV);
        send_ctrl(2'b10);
        wait_drain();
        exp_q.push_back(CONV_STEPS * FAST_DIV);
        send_ctrl(2'b00);
        repeat (10) @(negedge clk);
        check("R6 powered during int conv", pwr_up, 1);
        check("R3 code 00 keeps internal", ext_mode, 0);
        wait_drain();
        check("R6 asleep after int conv", pwr_up, 0);
        check("R10 ready held after int sleep", result_ready, 1);

        // R9 hardware shutdown aborts conversion
        pulse_start();
        exp_q.push_back(10);
        send_ctrl(2'b10);
        repeat (9) @(negedge clk);
        shdn_lvl = 2'b00;
        #1;
        check("R9 pin forces power off", pwr_up, 0);
        @(negedge clk);
        check("R9 strobe released", strobe, 1);
        check("R9 ready cleared", result_ready, 0);
        wait_drain();
        send_ctrl(2'b11);
        check("R9 byte ignored while low", ext_mode, 0);
        check("R9 no conversion while low", strobe, 1);
        shdn_lvl = 2'b11;
        @(negedge clk);
        check("R9 code 11 as open power", pwr_up, 1);
        check("R9 code 11 as open rate", slow_sel, 0);
        repeat (5) @(negedge clk);
        check("R4 queue drained", exp_q.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            summary();
            $finish;
        end
    end
endmodule